// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock-Out

This block is a 16-bit counter with a 16-bit reload register that software presets. Its plain use is as an upward timer. When it passes all-ones it takes the reload value and raises an overflow flag. A falling edge on a trigger pin can also reload it and raise an external flag, if edge reload is enabled. With up/down enabled, the level of the trigger pin sets the direction. Counting down ends when the count matches the reload value, and the counter then takes all-ones. In this mode the external flag acts as a 17th count bit that toggles on every wrap, and it takes no part in the interrupt request.

The counter advances on an enable pulse, and only while run is high. In the normal modes the pulse comes every twelfth clock. In the fast modes it comes every second clock. When the count-pin select is high, it comes from a synchronized falling edge on the count pin. The fast modes are baud generation and clock-out. In both, a wrap only reloads the counter, so the overflow flag stays quiet. Baud ticks for transmit and receive are one-clock pulses, one per sixteen wraps. The clock-out pin toggles on every wrap, which gives a square wave at 50% duty. Both flags stay set until a write to the clear port removes them.

Top module: `updown_reload_timer`

## Requirements
- R1: After a synchronous reset the count, reload value, both flags, the interrupt request, both baud ticks and the clock-out pin are all 0.
- R2: In up-only mode each advance adds one to the count. An advance at FFFFh loads the reload value and sets the overflow flag.
- R3: The count changes only when run is 1 or software writes it. A free-running prescaler issues an advance every 12th clock from reset, or every 2nd clock in the fast modes. When count_ext_i is 1, an advance is issued on each falling edge of the synchronized count pin instead.
- R4: Both pins pass through two flops, and a falling edge is acted on at the third rising clock edge after it. In up-only mode with edge_reload_en_i=1, a falling edge on the trigger pin loads the reload value and sets the external flag. With edge_reload_en_i=0 the edge has no effect.
- R5: In up/down mode the counter counts up while the synchronized trigger pin is 1 and down while it is 0. An advance downward while the count equals the reload value loads FFFFh and sets the overflow flag.
- R6: In up/down mode the external flag toggles on every wrap in either direction, and it does not drive the interrupt request.
- R7: irq_o is the OR of the overflow flag and the external flag (the external flag only outside up/down mode), and it is registered. flag_clr_i bit 0 clears the overflow flag and bit 1 clears the external flag. A hardware set wins over a clear in the same cycle.
- R8: The fast modes are active when either baud enable is 1, or when clkout_en_i=1 with the internal source selected. In a fast mode a wrap reloads the counter and leaves the overflow flag alone. A trigger falling edge with edge reload enabled sets the external flag and does not reload the counter.
- R9: In baud mode every 16th wrap gives a one-clock pulse on tx_tick_o when baud_tx_en_i=1, and on rx_tick_o when baud_rx_en_i=1.
- R10: clkout_o toggles on each wrap while clock-out is active, and it is 0 one cycle after clock-out is not active.
- R11: count_we_i loads count_wdata_i and takes priority over counting and over edge reload. reload_we_i loads reload_wdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Counting enable |
| count_ext_i | input | 1 | Select count-pin edges as the advance source |
| count_pin_i | input | 1 | External count pin, asynchronous |
| trig_pin_i | input | 1 | External trigger/direction pin, asynchronous |
| edge_reload_en_i | input | 1 | Enable trigger falling-edge action |
| updown_en_i | input | 1 | Enable up/down counting |
| baud_tx_en_i | input | 1 | Baud mode, transmit tick enable |
| baud_rx_en_i | input | 1 | Baud mode, receive tick enable |
| clkout_en_i | input | 1 | Clock-out enable |
| reload_we_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 16 | Reload write data |
| count_we_i | input | 1 | Count write strobe |
| count_wdata_i | input | 16 | Count write data |
| flag_clr_i | input | 2 | Flag clear: bit 0 overflow, bit 1 external |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| tx_tick_o | output | 1 | Transmit baud tick |
| rx_tick_o | output | 1 | Receive baud tick |
| clkout_o | output | 1 | Square-wave clock output |

## Verification
The bench builds the block with its default dividers: 12 for the slow prescaler, 2 for the fast prescaler and 16 for the baud divider. Because software can write the count, the wraps at FFFFh and at the reload value are reached in a few dozen clocks. A reload of FFFCh makes a fast-mode wrap every eight clocks. That puts two transmit ticks and a dozen clock-out toggles within a few hundred cycles.

// File: rtl/urt_pkg.sv
package urt_pkg;
  localparam int URT_W = 16;
  typedef logic [URT_W-1:0] urt_word_t;

  typedef struct packed {
    logic baud;
    logic clkout;
    logic fast;
    logic updown;
  } urt_mode_t;
endpackage

// File: rtl/urt_sync_edge.sv
module urt_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign fall_o  = s3_q & ~s2_q;

  // R4: a detected edge lasts exactly one clock
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/urt_pulse_div.sv
module urt_pulse_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic pulse_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (en_i)
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign pulse_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
  import urt_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2,
  parameter int BAUD_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              count_ext_i,
  input  logic              count_pin_i,
  input  logic              trig_pin_i,
  input  logic              edge_reload_en_i,
  input  logic              updown_en_i,
  input  logic              baud_tx_en_i,
  input  logic              baud_rx_en_i,
  input  logic              clkout_en_i,
  input  logic              reload_we_i,
  input  logic [URT_W-1:0]  reload_wdata_i,
  input  logic              count_we_i,
  input  logic [URT_W-1:0]  count_wdata_i,
  input  logic [1:0]        flag_clr_i,
  output logic [URT_W-1:0]  count_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              irq_o,
  output logic              tx_tick_o,
  output logic              rx_tick_o,
  output logic              clkout_o
);
  localparam int NPIN = 2;
  localparam urt_word_t ALL_ONES = '1;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_fall;
  assign pin_raw = {trig_pin_i, count_pin_i};

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_sync
      urt_sync_edge u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_raw[g]),
        .level_o (pin_lvl[g]),
        .fall_o  (pin_fall[g])
      );
    end
  endgenerate

  logic slow_pulse, fast_pulse, baud_pulse, baud_adv;

  urt_pulse_div #(.DIV(SLOW_DIV)) u_slow (
    .clk(clk), .rst(rst), .en_i(1'b1), .pulse_o(slow_pulse));
  urt_pulse_div #(.DIV(FAST_DIV)) u_fast (
    .clk(clk), .rst(rst), .en_i(1'b1), .pulse_o(fast_pulse));
  urt_pulse_div #(.DIV(BAUD_DIV)) u_baud (
    .clk(clk), .rst(rst), .en_i(baud_adv), .pulse_o(baud_pulse));

  urt_word_t count_q, reload_q, count_d;
  logic      ovf_q, ext_q, irq_q, tx_q, rx_q, clk_q;
  logic      ovf_d, ext_d;
  urt_mode_t mode;
  logic      tick_src, adv, dir_up, edge_hit, at_top, at_floor, roll;

  always_comb begin
    mode.baud   = baud_rx_en_i | baud_tx_en_i;
    mode.clkout = clkout_en_i & ~count_ext_i;
    mode.fast   = mode.baud | mode.clkout;
    mode.updown = updown_en_i & ~mode.fast;
  end

  always_comb begin
    tick_src = count_ext_i ? pin_fall[0] : (mode.fast ? fast_pulse : slow_pulse);
    adv      = run_i & tick_src;
    dir_up   = ~mode.updown | pin_lvl[1];
    edge_hit = pin_fall[1] & edge_reload_en_i & ~mode.updown;
    at_top   = (count_q == ALL_ONES);
    at_floor = (count_q == reload_q);
    roll     = ~count_we_i & adv & (dir_up ? at_top : at_floor);
    baud_adv = roll & mode.baud;

    if (count_we_i)
      count_d = count_wdata_i;
    else if (edge_hit && !mode.fast)
      count_d = reload_q;
    else if (adv && dir_up)
      count_d = at_top ? reload_q : count_q + 1'b1;
    else if (adv)
      count_d = at_floor ? ALL_ONES : count_q - 1'b1;
    else
      count_d = count_q;

    ovf_d = (roll & ~mode.fast) | (ovf_q & ~flag_clr_i[0]);
    if (roll && mode.updown)
      ext_d = ~ext_q;
    else if (edge_hit)
      ext_d = 1'b1;
    else
      ext_d = ext_q & ~flag_clr_i[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      ovf_q    <= 1'b0;
      ext_q    <= 1'b0;
      irq_q    <= 1'b0;
      tx_q     <= 1'b0;
      rx_q     <= 1'b0;
      clk_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      if (reload_we_i)
        reload_q <= reload_wdata_i;
      ovf_q <= ovf_d;
      ext_q <= ext_d;
      irq_q <= ovf_d | (ext_d & ~mode.updown);
      tx_q  <= baud_pulse & baud_tx_en_i;
      rx_q  <= baud_pulse & baud_rx_en_i;
      clk_q <= mode.clkout ? (clk_q ^ roll) : 1'b0;
    end
  end

  assign count_o    = count_q;
  assign ovf_flag_o = ovf_q;
  assign ext_flag_o = ext_q;
  assign irq_o      = irq_q;
  assign tx_tick_o  = tx_q;
  assign rx_tick_o  = rx_q;
  assign clkout_o   = clk_q;

  assert_top_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && dir_up && at_top && !count_we_i) |=> (count_q == $past(reload_q)));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !count_we_i && !edge_hit) |=> $stable(count_q));

  assert_floor_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && !dir_up && at_floor && !count_we_i) |=> (count_q == ALL_ONES && ovf_q));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !flag_clr_i[0]) |=> ovf_q);

  assert_fast_no_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    (mode.fast && !ovf_q) |=> !ovf_q);

  assert_tx_gated_R9: assert property (@(posedge clk) disable iff (rst)
    tx_tick_o |-> $past(baud_tx_en_i));

  assert_clkout_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !mode.clkout |=> !clkout_o);
endmodule

// File: tb/sim_updown_reload_timer.sv
module sim_updown_reload_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic run_i = 0, count_ext_i = 0, count_pin_i = 1, trig_pin_i = 1;
  logic edge_reload_en_i = 0, updown_en_i = 0, baud_tx_en_i = 0, baud_rx_en_i = 0;
  logic clkout_en_i = 0, reload_we_i = 0, count_we_i = 0;
  logic [15:0] reload_wdata_i = 0, count_wdata_i = 0;
  logic [1:0] flag_clr_i = 0;
  logic [15:0] count_o;
  logic ovf_flag_o, ext_flag_o, irq_o, tx_tick_o, rx_tick_o, clkout_o;

  updown_reload_timer u0 (.*);

  int n_checks = 0, n_fail = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  logic [15:0] m_cnt, m_rel;
  bit m_ovf, m_ext, m_irq, m_tx, m_rx, m_clk;
  bit c1, c2, c3, t1, t2, t3;
  int p_slow, p_fast, p_baud;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_ovf = 0; m_ext = 0; m_irq = 0;
      m_tx = 0; m_rx = 0; m_clk = 0;
      c1 = 1; c2 = 1; c3 = 1; t1 = 1; t2 = 1; t3 = 1;
      p_slow = 0; p_fast = 0; p_baud = 0;
    end else begin
      bit cfall, tfall, baud, cko, fast, ud, src, adv, up, hit, roll, bp;
      logic [15:0] nxt;
      cfall = c3 && !c2;
      tfall = t3 && !t2;
      baud = baud_tx_en_i || baud_rx_en_i;
      cko  = clkout_en_i && !count_ext_i;
      fast = baud || cko;
      ud   = updown_en_i && !fast;
      src  = count_ext_i ? cfall : (fast ? (p_fast == 1) : (p_slow == 11));
      adv  = run_i && src;
      up   = !ud || t2;
      hit  = tfall && edge_reload_en_i && !ud;
      roll = !count_we_i && adv && (up ? (m_cnt == 16'hFFFF) : (m_cnt == m_rel));
      nxt  = m_cnt;
      if (count_we_i) nxt = count_wdata_i;
      else if (hit && !fast) nxt = m_rel;
      else if (adv) begin
        if (up) nxt = (m_cnt == 16'hFFFF) ? m_rel : m_cnt + 16'd1;
        else    nxt = (m_cnt == m_rel) ? 16'hFFFF : m_cnt - 16'd1;
      end
      m_cnt = nxt;
      if (reload_we_i) m_rel = reload_wdata_i;
      if (roll && !fast) m_ovf = 1; else if (flag_clr_i[0]) m_ovf = 0;
      if (roll && ud) m_ext = !m_ext;
      else if (hit) m_ext = 1;
      else if (flag_clr_i[1]) m_ext = 0;
      m_irq = m_ovf || (m_ext && !ud);
      bp = baud && roll && (p_baud == 15);
      if (baud && roll) p_baud = (p_baud + 1) % 16;
      m_tx = bp && baud_tx_en_i;
      m_rx = bp && baud_rx_en_i;
      m_clk = cko ? (m_clk ^ roll) : 1'b0;
      p_slow = (p_slow + 1) % 12;
      p_fast = (p_fast + 1) % 2;
      c3 = c2; c2 = c1; c1 = count_pin_i;
      t3 = t2; t2 = t1; t1 = trig_pin_i;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (count_o !== m_cnt || ovf_flag_o !== m_ovf || ext_flag_o !== m_ext ||
          irq_o !== m_irq || tx_tick_o !== m_tx || rx_tick_o !== m_rx ||
          clkout_o !== m_clk) begin
        n_fail++;
        $display("FAIL %s: actual cnt=%h ovf=%b ext=%b irq=%b tx=%b rx=%b ck=%b expected cnt=%h ovf=%b ext=%b irq=%b tx=%b rx=%b ck=%b",
                 cur_req, count_o, ovf_flag_o, ext_flag_o, irq_o, tx_tick_o, rx_tick_o, clkout_o,
                 m_cnt, m_ovf, m_ext, m_irq, m_tx, m_rx, m_clk);
      end
    end
  end

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_count(logic [15:0] v);
    count_wdata_i = v; count_we_i = 1; wait_clk(1); count_we_i = 0;
  endtask

  task automatic set_reload(logic [15:0] v);
    reload_wdata_i = v; reload_we_i = 1; wait_clk(1); reload_we_i = 0;
  endtask

  task automatic clear_flags(logic [1:0] m);
    flag_clr_i = m; wait_clk(1); flag_clr_i = 0;
  endtask

  initial begin
    wait_clk(3);
    rst = 0;
    wait_clk(1);
    // R1 reset state
    check("R1", count_o, 0); check("R1", ovf_flag_o, 0); check("R1", ext_flag_o, 0);
    check("R1", irq_o, 0); check("R1", clkout_o, 0); check("R1", tx_tick_o, 0);

    // R2 / R11: up-only wrap at FFFFh
    cur_req = "R2";
    set_reload(16'h1234);
    set_count(16'hFFFA);
    run_i = 1;
    wait_clk(100);
    check("R2", ovf_flag_o, 1);
    check("R2", (count_o >= 16'h1234 && count_o < 16'h1240) ? 1 : 0, 1);
    check("R7", irq_o, 1);

    // R7: clear overflow flag
    cur_req = "R7";
    clear_flags(2'b01);
    wait_clk(2);
    check("R7", ovf_flag_o, 0); check("R7", irq_o, 0);

    // R3: run low holds, then external count pin edges
    cur_req = "R3";
    run_i = 0;
    set_count(16'h0100);
    wait_clk(50);
    check("R3", count_o, 16'h0100);
    run_i = 1; count_ext_i = 1;
    for (int k = 0; k < 5; k++) begin
      count_pin_i = 0; wait_clk(4); count_pin_i = 1; wait_clk(4);
    end
    check("R3", count_o, 16'h0105);
    count_ext_i = 0;

    // R4: trigger edge reload, and no effect when disabled
    cur_req = "R4";
    run_i = 0;
    set_reload(16'h0777);
    edge_reload_en_i = 1;
    trig_pin_i = 0; wait_clk(5); trig_pin_i = 1; wait_clk(3);
    check("R4", count_o, 16'h0777); check("R4", ext_flag_o, 1); check("R7", irq_o, 1);
    clear_flags(2'b10);
    edge_reload_en_i = 0;
    set_count(16'h0042);
    trig_pin_i = 0; wait_clk(5); trig_pin_i = 1; wait_clk(3);
    check("R4", ext_flag_o, 0); check("R4", count_o, 16'h0042);

    // R5 / R6: up/down mode
    cur_req = "R5";
    updown_en_i = 1;
    set_reload(16'h1000);
    set_count(16'h1003);
    trig_pin_i = 0;
    run_i = 1;
    wait_clk(60);
    check("R5", ovf_flag_o, 1);
    check("R6", ext_flag_o, 1);
    cur_req = "R6";
    clear_flags(2'b01);
    wait_clk(2);
    check("R6", irq_o, 0);
    trig_pin_i = 1;
    wait_clk(60);
    check("R6", ext_flag_o, 0);
    check("R5", (count_o >= 16'h1000 && count_o < 16'h1008) ? 1 : 0, 1);
    updown_en_i = 0;
    clear_flags(2'b11);

    // R8 / R9: baud mode
    cur_req = "R9";
    begin
      int txn = 0;
      set_reload(16'hFFFC);
      set_count(16'hFFFC);
      baud_tx_en_i = 1;
      edge_reload_en_i = 1;
      for (int k = 0; k < 300; k++) begin
        if (k == 40) trig_pin_i = 0;
        if (k == 45) trig_pin_i = 1;
        wait_clk(1);
        if (tx_tick_o) txn++;
      end
      check("R9", txn, 2);
      check("R8", ovf_flag_o, 0);
      check("R8", ext_flag_o, 1);
      check("R9", rx_tick_o, 0);
      baud_tx_en_i = 0;
      edge_reload_en_i = 0;
    end

    // R10: clock-out
    cur_req = "R10";
    begin
      int tog = 0;
      bit last = clkout_o;
      clkout_en_i = 1;
      for (int k = 0; k < 100; k++) begin
        wait_clk(1);
        if (clkout_o != last) tog++;
        last = clkout_o;
      end
      check("R10", (tog >= 11 && tog <= 13) ? 1 : 0, 1);
      clkout_en_i = 0;
      wait_clk(2);
      check("R10", clkout_o, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule